// File: doc/BRIEF.md
# Serial Control Register Bank with Frame-Synchronous Update

This block is the control-plane slave for a horizontal sample-rate converter. A host drives a three-wire synchronous serial bus: a serial clock, a bidirectional data line and a vertical reset pulse. The slave assembles 8-bit words with no parity bit, least significant bit first, sampled on the rising serial clock. Each transaction is one address word followed by one data word. Addresses 40h to 48h hold the curve breakpoints, the line length, the base rate and curvature terms, and a control byte. Address 49h is a read that returns an identification value of 00h.

Writes land in shadow registers. While the transfer bit of the shadow control byte is clear, the active copy follows the shadow copy at once. While it is set, the active copy takes the shadow values only on a rising edge of the vertical reset. That edge also restarts word framing and, when the init bit is set, produces a one-cycle init pulse. A keep bit freezes every curve-shaping field, so the datapath goes on using the curve it already has, while the other fields still update. All serial inputs are synchronised to the system clock. The serial clock must be several system clocks per half period.

Top module: `ctl_serial_regs`

## Requirements
- R1: After reset every field output, `init_pulse_o` and `ser_dat_oe_o` are 0.
- R2: Words are 8 bits, sampled on rising `ser_clk_i`, LSB first. A transaction is an address word followed by a data word.
- R3: The data word goes into the register it addresses: 40h `bp_outer_l_o`, 41h `bp_inner_l_o`, 42h `bp_inner_r_o`, 43h `bp_outer_r_o`, 44h `line_len_o`, 45h `rate_base_o`, 46h bits 5:0 `curv_inner_o` and bit 6 `split_en_o`, 47h bits 5:0 `curv_outer_o`, bit 6 `test_o[0]` and bit 7 `notch_en_o`.
- R4: Control byte 48h: bit 0 `zoom_o`, bit 1 `we_in_shift_o`, bit 2 `we_out_shift_o`, bit 3 init, bit 4 transfer, bit 5 `keep_o`, bit 6 `test_o[1]`, bit 7 `adapt_o`.
- R5: A write to any address outside 40h..48h changes no output.
- R6: After address 49h, the slave drives the data line (`ser_dat_oe_o`=1) for the next word with each bit 0. It releases the line afterwards, and nothing is written.
- R7: While shadow bit 4 of 48h is set, outputs hold until a rising edge of `vsync_rst_i` and then take the shadow values. While it is clear, writes appear on the outputs at once.
- R8: A rising edge of `vsync_rst_i` gives exactly one `init_pulse_o` cycle if shadow bit 3 of 48h is set, and none otherwise.
- R9: While shadow bit 5 of 48h is set, the curve fields hold their values even across a transfer: 40h..43h, 45h, and bits 5:0 of 46h and 47h. All other fields still update.
- R10: A rising edge of `vsync_rst_i` discards a partly received word and restarts at an address word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial bus clock |
| ser_dat_i | input | 1 | Serial data from host |
| ser_dat_o | output | 1 | Serial data to host |
| ser_dat_oe_o | output | 1 | Drive enable for serial data |
| vsync_rst_i | input | 1 | Vertical reset pulse |
| bp_outer_l_o | output | 8 | Left outer breakpoint |
| bp_inner_l_o | output | 8 | Left inner breakpoint |
| bp_inner_r_o | output | 8 | Right inner breakpoint |
| bp_outer_r_o | output | 8 | Right outer breakpoint |
| line_len_o | output | 8 | Programmed samples per line |
| rate_base_o | output | 8 | Constant rate increment of the centre area |
| curv_inner_o | output | 6 | Second-derivative term, inner areas |
| curv_outer_o | output | 6 | Second-derivative term, outer areas |
| split_en_o | output | 1 | Odd/even sample split enable |
| notch_en_o | output | 1 | Luma notch enable |
| zoom_o | output | 1 | Zoom direction in centre area |
| we_in_shift_o | output | 1 | Input write-enable phase select |
| we_out_shift_o | output | 1 | Output write-enable phase select |
| keep_o | output | 1 | Curve freeze flag |
| init_pulse_o | output | 1 | One-cycle initialise strobe |
| test_o | output | 2 | Test bits |
| adapt_o | output | 1 | Adapt bit |

## Verification
Two functions can meet on the same vertical reset edge: resynchronising the word framing and applying pending shadow values, with the keep gate also acting on that edge. The bench leaves a data word three bits in and then pulses the vertical reset while a transfer is pending. It judges the outputs against its shadow model and then checks that the next full transaction decodes correctly. A second case has keep and transfer both set on the same edge. It judges that the line length moves while every curve field stays put.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int          NUM_REGS   = 9;
  localparam logic [7:0]  BASE_ADDR  = 8'h40;
  localparam logic [7:0]  LAST_ADDR  = 8'(BASE_ADDR + NUM_REGS - 1);
  localparam logic [7:0]  ID_ADDR    = 8'h49;
  localparam logic [7:0]  ID_VALUE   = 8'h00;
  localparam int          CTRL_IDX   = NUM_REGS - 1;
  localparam int          CTRL_ZOOM  = 0;
  localparam int          CTRL_WEI   = 1;
  localparam int          CTRL_WEO   = 2;
  localparam int          CTRL_INIT  = 3;
  localparam int          CTRL_XFER  = 4;
  localparam int          CTRL_KEEP  = 5;
  localparam int          CTRL_TEST  = 6;
  localparam int          CTRL_ADAPT = 7;

  // bits of each register that shape the rate curve
  function automatic logic [7:0] curve_mask(input int idx);
    if (idx <= 3 || idx == 5) return 8'hFF;
    if (idx == 6 || idx == 7) return 8'h3F;
    return 8'h00;
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[g] <= '0;
      else if (g == 0) stg[g] <= d_i;
      else             stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ctl_shifter.sv
module ctl_shifter
  import ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       sdat_i,
  input  logic       vrst_i,
  output logic       vrst_rise_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       rd_act_o,
  output logic [2:0] bit_idx_o
);
  logic       sclk_q, vrst_q, sclk_rise;
  logic [2:0] bit_cnt;
  logic [7:0] shreg, nxt;
  logic       data_ph;

  assign sclk_rise   = sclk_i & ~sclk_q;
  assign vrst_rise_o = vrst_i & ~vrst_q;
  assign nxt         = {sdat_i, shreg[7:1]};
  assign bit_idx_o   = bit_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      vrst_q    <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      data_ph   <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      rd_act_o  <= 1'b0;
    end else begin
      sclk_q   <= sclk_i;
      vrst_q   <= vrst_i;
      wr_stb_o <= 1'b0;
      if (vrst_rise_o) begin
        bit_cnt  <= '0;
        data_ph  <= 1'b0;
        rd_act_o <= 1'b0;
      end else if (sclk_rise) begin
        shreg   <= nxt;
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (!data_ph) begin
            wr_addr_o <= nxt;
            data_ph   <= 1'b1;
            rd_act_o  <= (nxt == ID_ADDR);
          end else begin
            data_ph   <= 1'b0;
            rd_act_o  <= 1'b0;
            wr_stb_o  <= 1'b1;
            wr_data_o <= nxt;
          end
        end
      end
    end
  end

  assert_wr_after_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(data_ph));
  assert_vrst_reframe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vrst_rise_o |=> (bit_cnt == 3'd0 && !data_ph && !rd_act_o));
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_stb_i,
  input  logic [7:0]                wr_addr_i,
  input  logic [7:0]                wr_data_i,
  input  logic                      vrst_rise_i,
  output logic [NUM_REGS-1:0][7:0]  act_o,
  output logic                      init_pulse_o
);
  logic [NUM_REGS-1:0][7:0] sh_q;
  logic [7:0] off;
  logic       in_range, xfer_sh, keep_sh, apply;

  assign off      = wr_addr_i - BASE_ADDR;
  assign in_range = (wr_addr_i >= BASE_ADDR) && (wr_addr_i <= LAST_ADDR);
  assign xfer_sh  = sh_q[CTRL_IDX][CTRL_XFER];
  assign keep_sh  = sh_q[CTRL_IDX][CTRL_KEEP];
  assign apply    = !xfer_sh || vrst_rise_i;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] CM = curve_mask(i);
    logic [7:0] next_act;
    assign next_act = (sh_q[i] & ~CM) | ((keep_sh ? act_o[i] : sh_q[i]) & CM);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q[i]  <= '0;
        act_o[i] <= '0;
      end else begin
        if (wr_stb_i && in_range && off == 8'(i)) sh_q[i] <= wr_data_i;
        if (apply) act_o[i] <= next_act;
      end
    end

    assert_keep_curve_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      keep_sh |=> $stable(act_o[i] & CM));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_pulse_o <= 1'b0;
    else         init_pulse_o <= vrst_rise_i & sh_q[CTRL_IDX][CTRL_INIT];
  end

  assert_ignore_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !in_range) |=> $stable(sh_q));
  assert_hold_until_vrst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_sh && !vrst_rise_i) |=> $stable(act_o));
  assert_init_on_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_pulse_o |-> $past(vrst_rise_i));
endmodule

// File: rtl/ctl_serial_regs.sv
module ctl_serial_regs
  import ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ser_clk_i,
  input  logic       ser_dat_i,
  output logic       ser_dat_o,
  output logic       ser_dat_oe_o,
  input  logic       vsync_rst_i,
  output logic [7:0] bp_outer_l_o,
  output logic [7:0] bp_inner_l_o,
  output logic [7:0] bp_inner_r_o,
  output logic [7:0] bp_outer_r_o,
  output logic [7:0] line_len_o,
  output logic [7:0] rate_base_o,
  output logic [5:0] curv_inner_o,
  output logic [5:0] curv_outer_o,
  output logic       split_en_o,
  output logic       notch_en_o,
  output logic       zoom_o,
  output logic       we_in_shift_o,
  output logic       we_out_shift_o,
  output logic       keep_o,
  output logic       init_pulse_o,
  output logic [1:0] test_o,
  output logic       adapt_o
);
  logic [2:0] sync_q;
  logic       vrst_rise, wr_stb, rd_act;
  logic [7:0] wr_addr, wr_data;
  logic [2:0] bit_idx;
  logic [NUM_REGS-1:0][7:0] act;
  logic       unused_bits;

  ctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({vsync_rst_i, ser_dat_i, ser_clk_i}),
    .q_o (sync_q)
  );

  ctl_shifter u_shift (
    .clk_i, .rst_ni,
    .sclk_i      (sync_q[0]),
    .sdat_i      (sync_q[1]),
    .vrst_i      (sync_q[2]),
    .vrst_rise_o (vrst_rise),
    .wr_stb_o    (wr_stb),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .rd_act_o    (rd_act),
    .bit_idx_o   (bit_idx)
  );

  ctl_regbank u_bank (
    .clk_i, .rst_ni,
    .wr_stb_i     (wr_stb),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .vrst_rise_i  (vrst_rise),
    .act_o        (act),
    .init_pulse_o (init_pulse_o)
  );

  assign ser_dat_oe_o   = rd_act;
  assign ser_dat_o      = rd_act & ID_VALUE[bit_idx];

  assign bp_outer_l_o   = act[0];
  assign bp_inner_l_o   = act[1];
  assign bp_inner_r_o   = act[2];
  assign bp_outer_r_o   = act[3];
  assign line_len_o     = act[4];
  assign rate_base_o    = act[5];
  assign curv_inner_o   = act[6][5:0];
  assign split_en_o     = act[6][6];
  assign curv_outer_o   = act[7][5:0];
  assign test_o         = {act[CTRL_IDX][CTRL_TEST], act[7][6]};
  assign notch_en_o     = act[7][7];
  assign zoom_o         = act[CTRL_IDX][CTRL_ZOOM];
  assign we_in_shift_o  = act[CTRL_IDX][CTRL_WEI];
  assign we_out_shift_o = act[CTRL_IDX][CTRL_WEO];
  assign keep_o         = act[CTRL_IDX][CTRL_KEEP];
  assign adapt_o        = act[CTRL_IDX][CTRL_ADAPT];
  assign unused_bits    = ^{act[6][7], act[CTRL_IDX][CTRL_INIT], act[CTRL_IDX][CTRL_XFER]};

  assert_line_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_dat_oe_o |-> !ser_dat_o);
endmodule

// File: tb/ctl_serial_regs_test.sv
module ctl_serial_regs_test;
  logic clk = 0, rst_ni = 0;
  logic sclk = 0, sdat = 0, vrst = 0;
  logic dat_o, oe;
  logic [7:0] b0, b1, b2, b3, ll, rb;
  logic [5:0] ci, co;
  logic sp, nt, zm, wi, wo, kp, ip, ad;
  logic [1:0] ts;
  int total = 0, bad = 0;
  logic [7:0] sh [9];
  logic [7:0] ac [9];

  always #2.5 clk = ~clk;

  ctl_serial_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .ser_dat_o(dat_o), .ser_dat_oe_o(oe), .vsync_rst_i(vrst),
    .bp_outer_l_o(b0), .bp_inner_l_o(b1), .bp_inner_r_o(b2), .bp_outer_r_o(b3),
    .line_len_o(ll), .rate_base_o(rb), .curv_inner_o(ci), .curv_outer_o(co),
    .split_en_o(sp), .notch_en_o(nt), .zoom_o(zm), .we_in_shift_o(wi),
    .we_out_shift_o(wo), .keep_o(kp), .init_pulse_o(ip), .test_o(ts), .adapt_o(ad)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] obs_mask(input int i);
    if (i == 6) return 8'h7F;
    if (i == 8) return 8'hE7;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] cmask(input int i);
    if (i <= 3 || i == 5) return 8'hFF;
    if (i == 6 || i == 7) return 8'h3F;
    return 8'h00;
  endfunction

  function automatic logic [7:0] get_reg(input int i);
    case (i)
      0: return b0;  1: return b1;  2: return b2;  3: return b3;
      4: return ll;  5: return rb;
      6: return {1'b0, sp, ci};
      7: return {nt, ts[0], co};
      default: return {ad, ts[1], kp, 2'b00, wo, wi, zm};
    endcase
  endfunction

  task automatic apply_model();
    for (int i = 0; i < 9; i++)
      ac[i] = sh[8][5] ? ((sh[i] & ~cmask(i)) | (ac[i] & cmask(i))) : sh[i];
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 9; i++)
      chk($sformatf("%s reg%0d", tag, i), get_reg(i), ac[i] & obs_mask(i));
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int k = 0; k < nbits; k++) begin
      sclk = 0; sdat = b[k]; clks(6);
      sclk = 1; clks(6);
    end
    sclk = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    send_bits(a, 8);
    send_bits(d, 8);
    clks(10);
    if (a >= 8'h40 && a <= 8'h48) begin
      sh[a - 8'h40] = d;
      if (!sh[8][4]) apply_model();
    end
  endtask

  task automatic pulse_vrst(input string tag);
    int cnt = 0;
    int exp_init = sh[8][3];
    vrst = 1;
    for (int k = 0; k < 8; k++) begin @(negedge clk); cnt += ip; end
    vrst = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); cnt += ip; end
    if (sh[8][4]) apply_model();
    chk({tag, " R8 init pulses"}, cnt, exp_init);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) begin sh[i] = 0; ac[i] = 0; end
    clks(4);
    rst_ni = 1;
    clks(4);
    // R1 reset state
    check_all("R1 reset");
    chk("R1 oe", oe, 0);
    chk("R1 init", ip, 0);

    // R2 R3 R4 immediate writes, sweep of address and pattern
    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < 9; i++) begin
        logic [7:0] v;
        v = (p == 0) ? 8'hFF : (p == 1) ? 8'hA5 : (p == 2) ? 8'h5A : 8'(i * 29 + p * 7 + 3);
        if (i == 8) v = v & 8'hC7;  // leave init, transfer and keep clear
        wr(8'h40 + 8'(i), v);
        check_all($sformatf("R3 R4 imm p%0d a%0d", p, i));
      end
    end

    // R5 out-of-range writes
    begin
      logic [7:0] bad_a [6] = '{8'h00, 8'h3F, 8'h49, 8'h4A, 8'h80, 8'hFF};
      for (int k = 0; k < 6; k++) begin
        wr(bad_a[k], 8'h96);
        check_all($sformatf("R5 addr %0h", bad_a[k]));
      end
    end

    // R6 identification read
    chk("R6 oe idle", oe, 0);
    send_bits(8'h49, 8);
    for (int k = 0; k < 8; k++) begin
      sclk = 0; sdat = 1; clks(6);
      chk($sformatf("R6 oe bit%0d", k), oe, 1);
      chk($sformatf("R6 data bit%0d", k), dat_o, 0);
      sclk = 1; clks(6);
    end
    sclk = 0; sdat = 0; clks(10);
    chk("R6 oe released", oe, 0);
    check_all("R6 no write");

    // R7 deferred transfer
    wr(8'h48, 8'h17);
    check_all("R7 ctrl deferred");
    for (int i = 0; i < 8; i++) begin
      wr(8'h40 + 8'(i), 8'(8'h11 * (i + 1)));
      check_all($sformatf("R7 hold a%0d", i));
    end
    pulse_vrst("R7");
    check_all("R7 after vrst");

    // R8 init pulse set and clear
    wr(8'h48, 8'h18);
    pulse_vrst("R8 set");
    check_all("R8 set");
    wr(8'h48, 8'h10);
    pulse_vrst("R8 clear");

    // R9 keep with transfer on the same edge
    wr(8'h48, 8'h30);
    for (int i = 0; i < 8; i++) wr(8'h40 + 8'(i), 8'(8'hE3 - i * 17));
    check_all("R9 pending");
    pulse_vrst("R9");
    check_all("R9 curve frozen, rest moves");
    // R9 keep in immediate mode
    wr(8'h48, 8'h20);
    wr(8'h41, 8'h3C);
    wr(8'h44, 8'h77);
    check_all("R9 immediate keep");

    // R10 vrst mid-word together with a pending transfer
    wr(8'h48, 8'h10);
    wr(8'h42, 8'h9D);
    send_bits(8'h44, 8);
    send_bits(8'hFF, 3);
    clks(6);
    pulse_vrst("R10");
    check_all("R10 transfer at reframe");
    wr(8'h44, 8'h2B);
    pulse_vrst("R10 b");
    check_all("R10 next transaction");
    chk("R10 line len", ll, 8'h2B);

    // back to immediate mode
    wr(8'h48, 8'h00);
    check_all("R7 immediate again");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule